// File: doc/BRIEF.md
# Timestamp Counter with Compare and Capture

This block keeps a 32-bit time base that advances by one on each cycle in which the tick-enable input is high. It wraps from all ones back to zero. A host on an 8-bit register port sees the count as four byte registers. A read of the lowest byte also freezes the upper three bytes in a shadow copy, so a byte-by-byte read returns one coherent value even though the count keeps moving. A pause bit stops the count. While it is set, the host may load the count one byte at a time.

A second 32-bit register, also seen as four bytes, has one of two roles, chosen by a 2-bit mode field. As a comparator, it raises a sticky interrupt when the count becomes equal to the value the host wrote. As a capture latch, it stores the count at the moment one of eight enabled event strobes fires. The host enables each event with its own bit.

Top module: `tsc_unit`

## Requirements
- R1: After reset the count is 0, the compare/capture value is 0xFFFFFFFF, pause is clear, the mode is 00, all event enables are clear and irq is low.
- R2: When pause is clear, the count rises by one at each clock edge with tick_en high and wraps from 0xFFFFFFFF to 0. It holds when tick_en is low or pause is set.
- R3: A read of address 0x009 returns the live count bits [7:0] and copies count bits [31:8] into a shadow. Reads of 0x00A, 0x00B and 0x00C return shadow bits [15:8], [23:16] and [31:24], and they do not change until the next read of 0x009. Read data appears on host_rdata one clock after the read strobe.
- R4: In the control register at 0x008, bit 0 is pause and bit 1 reads back the interrupt flag. Writing 1 to bit 1 clears the flag.
- R5: While paused, a write to 0x009 to 0x00C replaces count byte 0 to 3. Counting resumes from the loaded value once pause is cleared.
- R6: Writes to the count bytes have no effect while pause is clear.
- R7: Register 0x011 holds the mode in bits [1:0] and the enables for events 0 to 5 in bits [7:2]. Register 0x012 bits [1:0] enable events 6 and 7. The compare/capture bytes sit at 0x00D (bits [7:0]) through 0x010 (bits [31:24]).
- R8: In mode 10 the flag, and with it irq, is set one clock after the count first equals the compare value. It is set once for each equality event, so it stays clear after a host clear while the count still equals the value.
- R9: In mode 01 the compare/capture register takes the count value present at a clock edge where an enabled event strobe is high. Strobes whose enable bit is clear do nothing.
- R10: In mode 01, host writes to the compare/capture bytes are ignored. A capture wins over a write in the same cycle.
- R11: In modes 00 and 11 no capture happens and the flag never sets. In every mode except 01 the host may write the compare/capture bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-advance enable, one clock per step |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 12 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data, valid one clock after host_rd |
| evt_strobe | input | 8 | One-clock event pulses, bit n is event n |
| irq | output | 1 | Active-high sticky compare interrupt |

## Verification
The bench loads a count just below all ones and ticks it across the wrap. A design that carried the wrong way would read back garbage bytes. It reads the high byte before and after a fresh low-byte read, so a shadow that tracked the live count would expose the newly written byte too early. It times the interrupt to the exact cycle and clears it while the count still matches; a level-driven flag would come straight back. It fires a disabled event, an enabled event on each enable register, and a capture together with a host write. A design that ignored the enables, accepted the write or let the write win would leave the wrong bytes in the capture register.

// File: rtl/tsc_pkg.sv
// Shared constants and types for the timestamp counter.
// Assumes an 8-bit host bus and a 32-bit count split into four bytes.
package tsc_pkg;
    localparam int CNT_W  = 32;
    localparam int NBYTE  = CNT_W / 8;
    localparam int N_EVT  = 8;
    localparam int EVT_LO = 6;              // enables held in the mode register
    localparam int EVT_HI = N_EVT - EVT_LO; // enables held in the next register
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_CTRL  = 12'h008;
    localparam logic [ADDR_W-1:0] A_CNT0  = 12'h009;
    localparam logic [ADDR_W-1:0] A_CMP0  = 12'h00D;
    localparam logic [ADDR_W-1:0] A_MODE  = 12'h011;
    localparam logic [ADDR_W-1:0] A_EVTHI = 12'h012;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_CAP  = 2'b01,
        MODE_CMP  = 2'b10,
        MODE_OFF2 = 2'b11
    } tsc_mode_e;
endpackage

// File: rtl/tsc_regs.sv
// Host register decode for the timestamp counter: holds pause, mode and
// event enables, generates per-byte write selects and registers read data.
// Assumes single-cycle strobes; read data is valid one clock after host_rd.
module tsc_regs
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic [7:0]        cnt_lo,
    input  logic [CNT_W-9:0]  snap,
    input  logic [CNT_W-1:0]  cmp,
    input  logic              flag,
    output logic              pause,
    output tsc_mode_e         mode,
    output logic [N_EVT-1:0]  evt_en,
    output logic [NBYTE-1:0]  cnt_wsel,
    output logic [NBYTE-1:0]  cmp_wsel,
    output logic              clr_flag,
    output logic              rd_lsb,
    output logic [7:0]        rdata
);
    logic [7:0] rd_nxt;

    // Per-byte write selects for the count and the compare/capture register.
    for (genvar b = 0; b < NBYTE; b++) begin : g_sel
        assign cnt_wsel[b] = host_wr && (host_addr == ADDR_W'(A_CNT0 + b));
        assign cmp_wsel[b] = host_wr && (host_addr == ADDR_W'(A_CMP0 + b));
    end

    assign clr_flag = host_wr && (host_addr == A_CTRL) && host_wdata[1];
    assign rd_lsb   = host_rd && (host_addr == A_CNT0);

    // Control, mode and enable registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause  <= 1'b0;
            mode   <= MODE_OFF;
            evt_en <= '0;
        end else if (host_wr) begin
            if (host_addr == A_CTRL)
                pause <= host_wdata[0];
            if (host_addr == A_MODE) begin
                mode                <= tsc_mode_e'(host_wdata[1:0]);
                evt_en[EVT_LO-1:0]  <= host_wdata[7:8-EVT_LO];
            end
            if (host_addr == A_EVTHI)
                evt_en[N_EVT-1:EVT_LO] <= host_wdata[EVT_HI-1:0];
        end
    end

    // Read multiplexer: selects the byte addressed by the host.
    always_comb begin
        rd_nxt = '0;
        if (host_addr == A_CTRL)
            rd_nxt = {6'b0, flag, pause};
        if (host_addr == A_CNT0)
            rd_nxt = cnt_lo;
        for (int b = 1; b < NBYTE; b++)
            if (host_addr == ADDR_W'(A_CNT0 + b))
                rd_nxt = snap[8*(b-1) +: 8];
        for (int b = 0; b < NBYTE; b++)
            if (host_addr == ADDR_W'(A_CMP0 + b))
                rd_nxt = cmp[8*b +: 8];
        if (host_addr == A_MODE)
            rd_nxt = {evt_en[EVT_LO-1:0], mode};
        if (host_addr == A_EVTHI)
            rd_nxt = {{(8-EVT_HI){1'b0}}, evt_en[N_EVT-1:EVT_LO]};
    end

    // Read data register, loaded on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (host_rd)
            rdata <= rd_nxt;
    end
endmodule

// File: rtl/tsc_counter.sv
// The free-running count and its read shadow. Counts on tick_en when not
// paused; accepts byte loads only while paused. The shadow takes the upper
// bytes whenever the low byte is read.
module tsc_counter
    import tsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             pause,
    input  logic [NBYTE-1:0] wsel,
    input  logic [7:0]       wdata,
    input  logic             rd_lsb,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-9:0] snap
);
    logic [CNT_W-1:0] cnt_nxt;

    // Next count: byte loads when paused, increment when running.
    always_comb begin
        cnt_nxt = cnt;
        if (pause) begin
            for (int b = 0; b < NBYTE; b++)
                if (wsel[b])
                    cnt_nxt[8*b +: 8] = wdata;
        end else if (tick_en) begin
            cnt_nxt = cnt + CNT_W'(1);
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

    // Shadow of the upper bytes, frozen by a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap <= '0;
        else if (rd_lsb)
            snap <= cnt[CNT_W-1:8];
    end
endmodule

// File: rtl/tsc_cmpcap.sv
// Compare/capture register and interrupt flag. In capture mode it loads
// the count on an enabled event and refuses host writes; in compare mode
// it sets a sticky flag on the first cycle of equality.
module tsc_cmpcap
    import tsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tsc_mode_e        mode,
    input  logic [N_EVT-1:0] evt_en,
    input  logic [N_EVT-1:0] evt_strobe,
    input  logic [CNT_W-1:0] cnt,
    input  logic [NBYTE-1:0] wsel,
    input  logic [7:0]       wdata,
    input  logic             clr_flag,
    output logic [CNT_W-1:0] cmp,
    output logic             flag
);
    logic             cap_hit;
    logic             eq_now;
    logic             eq_q;
    logic [CNT_W-1:0] cmp_nxt;

    // Capture trigger and equality detection.
    always_comb begin
        cap_hit = (mode == MODE_CAP) && (|(evt_strobe & evt_en));
        eq_now  = (mode == MODE_CMP) && (cnt == cmp);
    end

    // Next register value: capture first, then host byte writes.
    always_comb begin
        cmp_nxt = cmp;
        if (cap_hit) begin
            cmp_nxt = cnt;
        end else if (mode != MODE_CAP) begin
            for (int b = 0; b < NBYTE; b++)
                if (wsel[b])
                    cmp_nxt[8*b +: 8] = wdata;
        end
    end

    // Compare/capture register and equality history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp  <= '1;
            eq_q <= 1'b0;
        end else begin
            cmp  <= cmp_nxt;
            eq_q <= eq_now;
        end
    end

    // Sticky flag: set on a new equality, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (eq_now && !eq_q)
            flag <= 1'b1;
        else if (clr_flag)
            flag <= 1'b0;
    end
endmodule

// File: rtl/tsc_unit.sv
// Top of the timestamp counter: wires host decode, count and
// compare/capture together; irq follows the sticky compare flag.
module tsc_unit
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [N_EVT-1:0]  evt_strobe,
    output logic              irq
);
    logic             pause_w;
    tsc_mode_e        mode_w;
    logic [N_EVT-1:0] evt_en_w;
    logic [NBYTE-1:0] cnt_wsel_w;
    logic [NBYTE-1:0] cmp_wsel_w;
    logic             clr_flag_w;
    logic             rd_lsb_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-9:0] snap_w;
    logic [CNT_W-1:0] cmp_w;
    logic             flag_w;

    tsc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .cnt_lo     (cnt_w[7:0]),
        .snap       (snap_w),
        .cmp        (cmp_w),
        .flag       (flag_w),
        .pause      (pause_w),
        .mode       (mode_w),
        .evt_en     (evt_en_w),
        .cnt_wsel   (cnt_wsel_w),
        .cmp_wsel   (cmp_wsel_w),
        .clr_flag   (clr_flag_w),
        .rd_lsb     (rd_lsb_w),
        .rdata      (host_rdata)
    );

    tsc_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .pause   (pause_w),
        .wsel    (cnt_wsel_w),
        .wdata   (host_wdata),
        .rd_lsb  (rd_lsb_w),
        .cnt     (cnt_w),
        .snap    (snap_w)
    );

    tsc_cmpcap u_cc (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_w),
        .evt_en     (evt_en_w),
        .evt_strobe (evt_strobe),
        .cnt        (cnt_w),
        .wsel       (cmp_wsel_w),
        .wdata      (host_wdata),
        .clr_flag   (clr_flag_w),
        .cmp        (cmp_w),
        .flag       (flag_w)
    );

    assign irq = flag_w;
endmodule

// File: rtl/tsc_unit_chk.sv
// Property checker for tsc_unit, attached by bind. Observes ports and the
// signals passed between the submodules; drives nothing.
module tsc_unit_chk
    import tsc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic [N_EVT-1:0]  evt_strobe,
    input logic              irq,
    input logic              pause,
    input logic [1:0]        mode,
    input logic [N_EVT-1:0]  evt_en,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic [CNT_W-9:0]  snap
);
    assert_rst_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && cmp == '1 && !irq && !pause && mode == 2'b00));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pause && tick_en) |=> cnt == $past(cnt) + CNT_W'(1));

    assert_runwr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pause && !tick_en) |=> $stable(cnt));

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !host_wr) |=> $stable(cnt));

    assert_snap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && host_addr == A_CNT0) |=> $stable(snap));

    assert_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mode == 2'b10 && cnt == cmp));

    assert_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && |(evt_strobe & evt_en)) |=> cmp == $past(cnt));

    assert_capwr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !(|(evt_strobe & evt_en))) |=> $stable(cmp));

    assert_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 || mode == 2'b11) |=> !$rose(irq));
endmodule

bind tsc_unit tsc_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .evt_strobe (evt_strobe),
    .irq        (irq),
    .pause      (pause_w),
    .mode       (mode_w),
    .evt_en     (evt_en_w),
    .cnt        (cnt_w),
    .cmp        (cmp_w),
    .snap       (snap_w)
);

// File: tb/tsc_unit_tb.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares
// host_rdata one clock after each read strobe.
module tsc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [11:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  evt_strobe = '0;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    logic mon_fire = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    tsc_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .evt_strobe (evt_strobe),
        .irq        (irq)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: a read strobe seen at an edge yields data by the next negedge.
    always @(posedge clk) mon_fire <= host_rd;
    always @(negedge clk) begin
        if (mon_fire) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard underrun", 0, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(host_rdata == e, t, host_rdata, e);
            end
        end
    end

    task automatic host_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [11:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic strobe(input int idx);
        @(negedge clk);
        evt_strobe = 8'(1 << idx);
        @(negedge clk);
        evt_strobe = '0;
    endtask

    task automatic load_cnt(input logic [31:0] v);
        host_write(12'h008, 8'h01);
        for (int b = 0; b < 4; b++) host_write(12'(12'h009 + b), v[8*b +: 8]);
        host_write(12'h008, 8'h00);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2_000_000;
        check(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        host_read(12'h008, 8'h00, "R1 control reset");
        host_read(12'h00D, 8'hFF, "R1 cmp byte0 reset");
        host_read(12'h010, 8'hFF, "R1 cmp byte3 reset");
        host_read(12'h009, 8'h00, "R1 count reset");
        host_read(12'h011, 8'h00, "R1 mode reset");

        // R5 paused byte loads; R4 pause readback
        host_write(12'h008, 8'h01);
        host_read(12'h008, 8'h01, "R4 pause bit readback");
        host_write(12'h009, 8'hFC);
        host_write(12'h00A, 8'hFF);
        host_write(12'h00B, 8'hFF);
        host_write(12'h00C, 8'hFF);
        host_read(12'h009, 8'hFC, "R5 loaded low byte");
        host_read(12'h00C, 8'hFF, "R5 loaded top byte via shadow");
        host_write(12'h008, 8'h00);

        // R2 wrap: 0xFFFFFFFC + 5 = 0x00000001
        ticks(5);
        host_read(12'h009, 8'h01, "R2 wrap low byte");
        host_read(12'h00A, 8'h00, "R2 wrap byte1");
        host_read(12'h00C, 8'h00, "R2 wrap byte3");

        // R3 shadow stays stale until the next low-byte read
        host_write(12'h008, 8'h01);
        host_write(12'h00C, 8'hAB);
        host_write(12'h008, 8'h00);
        host_read(12'h00C, 8'h00, "R3 shadow not refreshed");
        host_read(12'h009, 8'h01, "R3 low byte live");
        host_read(12'h00C, 8'hAB, "R3 shadow refreshed");
        host_read(12'h00B, 8'h00, "R3 shadow byte2");

        // R6 writes while running are ignored
        host_write(12'h00A, 8'h55);
        host_read(12'h009, 8'h01, "R6 low byte unchanged");
        host_read(12'h00A, 8'h00, "R6 byte1 unchanged");

        // R2 hold while paused, R5 resume from held value
        host_write(12'h008, 8'h01);
        ticks(3);
        host_read(12'h009, 8'h01, "R2 paused count holds");
        host_write(12'h008, 8'h00);
        ticks(2);
        host_read(12'h009, 8'h03, "R5 resumes counting");

        // R8 compare; R11 compare register writable in mode 00
        load_cnt(32'h0000_0010);
        host_write(12'h00D, 8'h13);
        host_write(12'h00E, 8'h00);
        host_write(12'h00F, 8'h00);
        host_write(12'h010, 8'h00);
        host_read(12'h00D, 8'h13, "R11 cmp writable in mode 00");
        host_write(12'h011, 8'h02);
        ticks(2);
        check(irq == 1'b0, "R8 no irq before match", irq, 0);
        ticks(1);
        check(irq == 1'b0, "R8 irq one clock after match", irq, 0);
        @(negedge clk);
        check(irq == 1'b1, "R8 irq raised", irq, 1);
        host_read(12'h008, 8'h02, "R4 flag readback");
        host_write(12'h008, 8'h02);
        @(negedge clk);
        @(negedge clk);
        check(irq == 1'b0, "R8 stays clear while still equal", irq, 0);
        host_read(12'h008, 8'h00, "R4 flag cleared");

        // R11 mode 11: no interrupt, no capture
        host_write(12'h011, 8'hFF);
        load_cnt(32'h0000_0012);
        ticks(1);
        @(negedge clk);
        @(negedge clk);
        check(irq == 1'b0, "R11 no irq in mode 11", irq, 0);
        strobe(0);
        host_read(12'h00D, 8'h13, "R11 no capture in mode 11");

        // R9 / R7 capture with enables for event 2 and event 7
        load_cnt(32'h1234_5678);
        host_write(12'h011, 8'h11);
        host_write(12'h012, 8'h02);
        host_read(12'h011, 8'h11, "R7 mode register readback");
        strobe(3);
        host_read(12'h00D, 8'h13, "R9 disabled event ignored");
        strobe(2);
        host_read(12'h00D, 8'h78, "R9 capture byte0");
        host_read(12'h00E, 8'h56, "R9 capture byte1");
        host_read(12'h00F, 8'h34, "R9 capture byte2");
        host_read(12'h010, 8'h12, "R9 capture byte3");
        ticks(3);
        strobe(7);
        host_read(12'h00D, 8'h7B, "R7 event 7 enabled from upper register");

        // R10 writes ignored in capture mode; capture beats write
        host_write(12'h00D, 8'h99);
        host_read(12'h00D, 8'h7B, "R10 write ignored in capture mode");
        ticks(1);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 12'h00E; host_wdata = 8'hEE; evt_strobe = 8'h04;
        @(negedge clk);
        host_wr = 1'b0; evt_strobe = '0;
        host_read(12'h00D, 8'h7C, "R10 capture wins byte0");
        host_read(12'h00E, 8'h56, "R10 capture wins byte1");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule